// File: doc/BRIEF.md
# Condition-Code Flag Unit with Branch Evaluator

This block performs a 32-bit integer operation (add, subtract, compare or a bitwise logical function) and, as a side effect, can capture five condition flags in dedicated one-bit registers. The flags are sign, zero, carry/borrow, signed overflow and low-byte parity. A conditional branch that comes later does not compare registers. It reads only the stored flags and a condition code, and reports whether the branch is taken.

Compare computes the same difference as subtract but marks the result as not to be written back. Software can therefore set flags without disturbing a register. Because the flags persist while the flag-update enable is low, a branch can also reuse the flags left by an earlier arithmetic operation and skip the compare.

Top module: `ccf_unit`

## Requirements
- R1: While rst_ni is low and after its release, all five flag outputs are 0 until the first enabled update. With cleared flags, the branch conditions NE, GT and GE are taken and EQ, LT and LE are not.
- R2: The operation codes on op_sel_i are 0 add (a+b), 1 subtract (a-b), 2 compare (a-b on result_o with res_we_o=0), 3 AND, 4 OR and 5 XOR, each with res_we_o=1. Codes 6 and 7 give result 0 and res_we_o=0. result_o and res_we_o are combinational.
- R3: When flag_en_i is high at a rising clock edge, all flags take the values of the current operation. When flag_en_i is low, every flag keeps its value.
- R4: flag_s_o is bit 31 of the result that was captured.
- R5: flag_z_o is 1 exactly when all 32 result bits were zero.
- R6: flag_c_o is the carry out of bit 31 for add. For subtract and compare it is 1 when a is unsigned-less-than b. Logical and reserved codes clear it.
- R7: flag_v_o is 1 on signed overflow of add, subtract or compare. Logical and reserved codes clear it.
- R8: flag_p_o is 1 when result bits 7..0 hold an even number of ones. Bits 31..8 have no effect on it.
- R9: taken_o depends only on the stored flags and cond_i. The codes are 0 EQ (z), 1 NE (!z), 2 LT (s^v), 3 LE ((s^v)|z), 4 GT (!((s^v)|z)) and 5 GE (!(s^v)). Codes 6 and 7 are never taken.
- R10: A compare leaves the same flags as a subtract of the same operands, so the signed branch conditions after it match the signed ordering of a and b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| op_sel_i | input | 3 | Operation code |
| flag_en_i | input | 1 | Capture flags at this edge |
| cond_i | input | 3 | Branch condition code |
| result_o | output | 32 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| flag_s_o | output | 1 | Stored sign flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry/borrow flag |
| flag_v_o | output | 1 | Stored signed overflow flag |
| flag_p_o | output | 1 | Stored low-byte parity flag |
| taken_o | output | 1 | Branch decision from stored flags |

## Verification
The hardest cases to reach are signed overflow crossing the sign boundary and parity that depends only on the low byte while upper bits toggle. Both need operands at the extremes, such as 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0xFFFFFF00. The bench sweeps every pair from a boundary-rich operand set through every operation code. After each capture it evaluates all eight branch codes. For subtract and compare, it checks the signed conditions against a direct signed comparison of the operands, not against its own flag model. A hold cycle then follows, with a different operation and flag_en_i low, to show that the stored flags and the branch decision do not move.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'd0,
    BR_NE  = 3'd1,
    BR_LT  = 3'd2,
    BR_LE  = 3'd3,
    BR_GT  = 3'd4,
    BR_GE  = 3'd5,
    BR_NV6 = 3'd6,
    BR_NV7 = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
    logic p;
  } flags_t;

  localparam int unsigned FLAG_N = $bits(flags_t);
endpackage

// File: rtl/ccf_alu.sv
module ccf_alu
  import ccf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output flags_t            flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W:0]   sum_w;
  logic [DATA_W:0]   dif_w;
  logic              arith;
  logic              v_add;
  logic              v_sub;

  assign op    = alu_op_e'(op_i);
  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};
  // signed overflow: result sign disagrees with what the operand signs imply
  assign v_add = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
  assign v_sub = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);

  always_comb begin
    res_o   = '0;
    we_o    = 1'b1;
    arith   = 1'b0;
    flags_o = '0;
    unique case (op)
      OP_ADD: begin
        res_o     = sum_w[MSB:0];
        arith     = 1'b1;
        flags_o.c = sum_w[DATA_W];
        flags_o.v = v_add;
      end
      OP_SUB, OP_CMP: begin
        res_o     = dif_w[MSB:0];
        we_o      = (op == OP_SUB);
        arith     = 1'b1;
        flags_o.c = dif_w[DATA_W];  // borrow
        flags_o.v = v_sub;
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: begin
        res_o = '0;
        we_o  = 1'b0;
      end
    endcase
    flags_o.s = res_o[MSB];
    flags_o.z = (res_o == '0);
    flags_o.p = ~^res_o[PAR_W-1:0];
  end

  // R6 R7
  always_comb begin
    if (!arith) logic_clr_chk: assert (!flags_o.c && !flags_o.v);
  end
endmodule

// File: rtl/ccf_flag_reg.sv
module ccf_flag_reg
  import ccf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= d_i;
  end

  assign q_o = q;

  // R3
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

  // R3
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/ccf_branch_eval.sv
module ccf_branch_eval
  import ccf_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [2:0] cond_i,
  output logic       taken_o
);
  br_cond_e cond;
  logic     lt;
  logic     le;

  assign cond = br_cond_e'(cond_i);
  assign lt   = flags_i.s ^ flags_i.v;
  assign le   = lt | flags_i.z;

  always_comb begin
    unique case (cond)
      BR_EQ:   taken_o = flags_i.z;
      BR_NE:   taken_o = !flags_i.z;
      BR_LT:   taken_o = lt;
      BR_LE:   taken_o = le;
      BR_GT:   taken_o = !le;
      BR_GE:   taken_o = !lt;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccf_unit.sv
module ccf_unit
  import ccf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [2:0]        op_sel_i,
  input  logic              flag_en_i,
  input  logic [2:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_we_o,
  output logic              flag_s_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic              flag_p_o,
  output logic              taken_o
);
  localparam int unsigned MSB = DATA_W - 1;

  flags_t flags_nxt;
  flags_t flags_q;

  ccf_alu #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_alu (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .op_i    (op_sel_i),
    .res_o   (result_o),
    .we_o    (res_we_o),
    .flags_o (flags_nxt)
  );

  ccf_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (flag_en_i),
    .d_i    (flags_nxt),
    .q_o    (flags_q)
  );

  ccf_branch_eval u_br (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .taken_o (taken_o)
  );

  assign flag_s_o = flags_q.s;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;
  assign flag_p_o = flags_q.p;

  // R4
  sign_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i |=> (flag_s_o == $past(result_o[MSB])));

  // R5
  zero_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i |=> (flag_z_o == ($past(result_o) == '0)));

  // R6 R10
  borrow_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op_sel_i == 3'd1 || op_sel_i == 3'd2))
      |=> (flag_c_o == ($past(op_a_i) < $past(op_b_i))));

  // R10
  cmp_lt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && op_sel_i == 3'd2)
      |=> ((flag_s_o ^ flag_v_o) == ($signed($past(op_a_i)) < $signed($past(op_b_i)))));

  // R2
  cmp_nowb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i == 3'd2) |-> (!res_we_o && result_o == op_a_i - op_b_i));
endmodule

// File: tb/ccf_unit_test.sv
`timescale 1ns/1ps
module ccf_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  op = '0, cond = '0;
  logic        fen = 1'b0;
  logic [31:0] result;
  logic        we, fs, fz, fc, fv, fp, taken;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ccf_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .op_sel_i(op),
    .flag_en_i(fen), .cond_i(cond), .result_o(result), .res_we_o(we),
    .flag_s_o(fs), .flag_z_o(fz), .flag_c_o(fc), .flag_v_o(fv),
    .flag_p_o(fp), .taken_o(taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h a=%h b=%h op=%0d cond=%0d",
               req, act, exp, a, b, op, cond);
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0000_00FF;
      6: return 32'h0000_0100;
      7: return 32'h1234_5678;
      8: return 32'hFFFF_FF00;
      default: return 32'h0000_0002;
    endcase
  endfunction

  logic [31:0] er;
  logic        ewe, es, ez, ec, ev, ep, elt, eeq;

  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o);
    logic [32:0] w;
    longint sx, sy, sr;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    ewe = 1'b1; ec = 1'b0; ev = 1'b0;
    case (o)
      3'd0: begin
        w = {1'b0, x} + {1'b0, y}; er = w[31:0]; ec = w[32];
        sr = sx + sy; ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd1, 3'd2: begin
        er = x - y; ec = (x < y); ewe = (o == 3'd1);
        sr = sx - sy; ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd3: er = x & y;
      3'd4: er = x | y;
      3'd5: er = x ^ y;
      default: begin er = '0; ewe = 1'b0; end
    endcase
    es = er[31];
    ez = (er == 0);
    ep = ($countones(er[7:0]) % 2) == 0;
    if (o == 3'd1 || o == 3'd2) begin
      elt = (sx < sy); eeq = (x == y);
    end else begin
      elt = es ^ ev; eeq = ez;
    end
  endtask

  function automatic logic exp_taken(input int c, input logic lt, input logic eq);
    case (c)
      0: return eq;
      1: return !eq;
      2: return lt;
      3: return lt | eq;
      4: return !(lt | eq);
      5: return !lt;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk_taken(input logic lt, input logic eq, input string req);
    for (int c = 0; c < 8; c++) begin
      cond = 3'(c);
      #1;
      chk(req, {31'd0, taken}, {31'd0, exp_taken(c, lt, eq)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 flags in reset", {27'd0, fs, fz, fc, fv, fp}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", {27'd0, fs, fz, fc, fv, fp}, 32'd0);
    chk_taken(1'b0, 1'b0, "R1 R9 taken after reset");

    for (int o = 0; o < 8; o++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          @(negedge clk);
          a = pick(i); b = pick(j); op = 3'(o); fen = 1'b1;
          model(a, b, op);
          #1;
          chk("R2 result", result, er);
          chk("R2 write-back", {31'd0, we}, {31'd0, ewe});
          @(negedge clk);
          fen = 1'b0;
          chk("R4 sign", {31'd0, fs}, {31'd0, es});
          chk("R5 zero", {31'd0, fz}, {31'd0, ez});
          chk("R6 carry", {31'd0, fc}, {31'd0, ec});
          chk("R7 overflow", {31'd0, fv}, {31'd0, ev});
          chk("R8 parity", {31'd0, fp}, {31'd0, ep});
          chk_taken(elt, eeq, (o == 2) ? "R10 R9 taken after compare" : "R9 taken");
          // R3 hold: different operation with enable low
          a = ~a ^ 32'h0000_0001; b = b + 32'd3; op = 3'(5 - (o % 6));
          @(negedge clk);
          chk("R3 hold", {27'd0, fs, fz, fc, fv, fp}, {27'd0, es, ez, ec, ev, ep});
          cond = 3'd3;
          #1;
          chk("R3 R9 hold taken", {31'd0, taken}, {31'd0, exp_taken(3, elt, eeq)});
        end
      end
    end

    // R8 upper bits ignored: same low byte, different upper bits
    @(negedge clk);
    a = 32'hA5A5_A503; b = 32'h0; op = 3'd4; fen = 1'b1;
    @(negedge clk);
    chk("R8 parity low byte only", {31'd0, fp}, 32'd1);
    a = 32'h0000_0003;
    @(negedge clk);
    fen = 1'b0;
    chk("R8 parity upper ignored", {31'd0, fp}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule